// File: doc/BRIEF.md
# Word-Aligned Stack Pointer Unit with Bounds Trap

This block owns the stack pointer of a small word-addressed data memory. It accepts push, pop and program-counter push requests, produces the memory address, the strobes and the write data for each access, and moves the pointer. The stack grows toward higher addresses, and the pointer always names the next free word. A push writes at the pointer and then adds 2. A pop subtracts 2 and then reads.

Each stack access is checked against two bounds. One is a programmable upper limit register. The other is a fixed floor at 0x0800. An access outside these bounds is not carried out: the memory is not touched and the pointer keeps its value. One cycle later a trap pulse appears, with a cause bit that tells overflow from underflow. A program-counter push writes a two-word frame over two consecutive cycles. The second word differs between an ordinary call and an exception entry.

A small state machine steers the sequencing. It has three states. ST_IDLE accepts requests and register writes. ST_PC_HI writes the second frame word, with busy high. ST_LIM_HOLD is a single blocked cycle after a limit write. The named transitions are:
- PC_START: ST_IDLE to ST_PC_HI, on an accepted PC push.
- PC_DONE: ST_PC_HI back to ST_IDLE.
- LIM_LOCK: ST_IDLE to ST_LIM_HOLD, on a limit write.
- LIM_FREE: ST_LIM_HOLD back to ST_IDLE.
- STAY: remain in ST_IDLE in every other case.

Top module: `stk_ptr_unit`

## Requirements
- R1: After reset the pointer reads 0x0800. busy, trap, mem_we and mem_re are all 0.
- R2: An accepted push drives mem_we=1, mem_addr equal to the pointer and mem_wdata equal to push_data in the request cycle. After the clock edge the pointer is 2 higher.
- R3: An accepted pop drives mem_re=1 and mem_addr equal to the pointer minus 2 in the request cycle. After the clock edge the pointer is 2 lower.
- R4: A pointer write loads reg_wdata with bit 0 cleared. A limit write stores reg_wdata with bit 0 cleared. For example, a limit of 0x0811 behaves as 0x0810. The limit has no reset value.
- R5: An access whose address is above the limit is an overflow. This means a push with the pointer equal to the limit succeeds, and the push after it traps with trap_under=0.
- R6: An access whose address is below 0x0800 is an underflow and traps with trap_under=1. A pop with the pointer at 0x0800 is one such access.
- R7: A trapping access drives neither mem_we nor mem_re and leaves the pointer unchanged. trap is high for exactly the one cycle after the offending request, unless the next request also traps.
- R8: A call-type PC push (pcpush_exc=0) takes two cycles. The first writes pc_val[15:0] at the pointer. The second, with busy high, writes {9'b0, pc_val[22:6+10]} at the pointer plus 2; its low 7 bits are pc_val[22:16]. The pointer ends 4 higher.
- R9: An exception-type PC push (pcpush_exc=1) writes a second word of {stat_low[7:0], 1'b0, pc_val[22:16]}. pc_val, stat_low and pcpush_exc are sampled in the first cycle.
- R10: In the cycle after a limit write, busy is high and every request is ignored.
- R11: In ST_IDLE the priority is register write, then PC push, then push, then pop. Requests and register writes made while busy is high are ignored.
- R12: If the second word of a PC push fails the bounds check, it is not written. The trap fires, and the pointer stays 2 above its starting value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_req | input | 1 | Push one data word |
| pop_req | input | 1 | Pop one data word |
| push_data | input | 16 | Data for a push |
| pcpush_req | input | 1 | Start a two-word PC frame push |
| pcpush_exc | input | 1 | 1 = exception frame, 0 = call frame |
| pc_val | input | 23 | Program counter to save |
| stat_low | input | 8 | Status low byte for exception frames |
| sp_wr | input | 1 | Load the pointer from reg_wdata |
| lim_wr | input | 1 | Load the limit from reg_wdata |
| reg_wdata | input | 16 | Register write data |
| mem_addr | output | 16 | Stack access address |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_wdata | output | 16 | Memory write data |
| busy | output | 1 | Requests are not accepted this cycle |
| sp_val | output | 16 | Current pointer |
| trap | output | 1 | Stack-error trap pulse |
| trap_under | output | 1 | Trap cause: 1 = underflow, 0 = overflow |

## Verification
A wrong pointer shows at the ports in the same cycle. It appears on mem_addr of the next push or pop, and on sp_val right after the edge. A limit that is off by one word moves the first trapping push by exactly one position, so a sweep of limits against a counted run of pushes shows it at once. A corrupted state register shows either as a missing second frame word or as busy at the wrong time, one cycle after the request that started the sequence. A wrong bounds decision shows as a strobe that should have been withheld, or as a trap pulse one cycle later than expected.

// File: rtl/stk_pkg.sv
package stk_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_PC_HI    = 2'd1,
        ST_LIM_HOLD = 2'd2
    } stk_state_e;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_PUSH  = 3'd1,
        OP_POP   = 3'd2,
        OP_PC_LO = 3'd3,
        OP_PC_HI = 3'd4
    } stk_op_e;

endpackage

// File: rtl/stk_addr_gen.sv
module stk_addr_gen #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] sp,
    input  logic          is_pop,
    output logic [DW-1:0] acc_addr,
    output logic [DW-1:0] sp_inc,
    output logic [DW-1:0] sp_dec,
    output logic          borrow
);
    localparam logic [DW:0] STEP = (DW+1)'(2);

    logic [DW:0] dec_full;

    always_comb begin
        dec_full = {1'b0, sp} - STEP;
        sp_dec   = dec_full[DW-1:0];
        sp_inc   = sp + DW'(2);
        borrow   = is_pop & dec_full[DW];
        acc_addr = is_pop ? sp_dec : sp;
    end
endmodule

// File: rtl/stk_bound_chk.sv
module stk_bound_chk #(
    parameter int              DW    = 16,
    parameter logic [DW-1:0]   FLOOR = 16'h0800
) (
    input  logic [DW-1:0] addr,
    input  logic [DW-1:0] lim,
    input  logic          borrow,
    output logic          over,
    output logic          under
);
    always_comb begin
        under = borrow | (addr < FLOOR);
        over  = ~under & (addr > lim);
    end
endmodule

// File: rtl/stk_frame_fmt.sv
module stk_frame_fmt #(
    parameter int DW  = 16,
    parameter int PCW = 23,
    parameter int SRW = 8
) (
    input  logic [PCW-1:0] pc,
    input  logic [SRW-1:0] sr,
    input  logic           is_exc,
    output logic [DW-1:0]  lo_word,
    output logic [DW-1:0]  hi_word
);
    localparam int UPW = PCW - DW;
    localparam int PAD = DW - UPW - SRW;

    logic [SRW-1:0] top_bits;

    assign lo_word  = pc[DW-1:0];
    assign top_bits = is_exc ? sr : '0;

    generate
        if (PAD > 0) begin : g_pad
            assign hi_word = {top_bits, {PAD{1'b0}}, pc[PCW-1:DW]};
        end else begin : g_nopad
            assign hi_word = {top_bits, pc[PCW-1:DW]};
        end
    endgenerate
endmodule

// File: rtl/stk_ptr_unit.sv
module stk_ptr_unit
    import stk_pkg::*;
#(
    parameter int            DW     = 16,
    parameter int            PCW    = 23,
    parameter int            SRW    = 8,
    parameter logic [DW-1:0] FLOOR  = 16'h0800,
    parameter logic [DW-1:0] SP_RST = 16'h0800
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           push_req,
    input  logic           pop_req,
    input  logic [DW-1:0]  push_data,
    input  logic           pcpush_req,
    input  logic           pcpush_exc,
    input  logic [PCW-1:0] pc_val,
    input  logic [SRW-1:0] stat_low,
    input  logic           sp_wr,
    input  logic           lim_wr,
    input  logic [DW-1:0]  reg_wdata,
    output logic [DW-1:0]  mem_addr,
    output logic           mem_we,
    output logic           mem_re,
    output logic [DW-1:0]  mem_wdata,
    output logic           busy,
    output logic [DW-1:0]  sp_val,
    output logic           trap,
    output logic           trap_under
);
    localparam logic [DW-1:0] ALIGN_MASK = ~DW'(1);

    stk_state_e    state_q, state_d;
    stk_op_e       op;
    logic [DW-1:0] sp_q, sp_d;
    logic [DW-1:0] lim_q;
    logic [DW-1:0] hi_q;
    logic          trap_q, under_q;

    logic [DW-1:0] acc_addr, sp_inc, sp_dec;
    logic [DW-1:0] lo_word, hi_word;
    logic          borrow, over, under, access, bad, reg_acc;

    stk_addr_gen #(.DW(DW)) u_addr (
        .sp       (sp_q),
        .is_pop   (op == OP_POP),
        .acc_addr (acc_addr),
        .sp_inc   (sp_inc),
        .sp_dec   (sp_dec),
        .borrow   (borrow)
    );

    stk_bound_chk #(.DW(DW), .FLOOR(FLOOR)) u_chk (
        .addr   (acc_addr),
        .lim    (lim_q),
        .borrow (borrow),
        .over   (over),
        .under  (under)
    );

    stk_frame_fmt #(.DW(DW), .PCW(PCW), .SRW(SRW)) u_fmt (
        .pc      (pc_val),
        .sr      (stat_low),
        .is_exc  (pcpush_exc),
        .lo_word (lo_word),
        .hi_word (hi_word)
    );

    // operation select and next state
    always_comb begin
        op      = OP_NONE;
        state_d = state_q;
        reg_acc = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (sp_wr || lim_wr) begin
                    reg_acc = 1'b1;
                    if (lim_wr) state_d = ST_LIM_HOLD;      // LIM_LOCK
                end else if (pcpush_req) begin
                    op = OP_PC_LO;
                end else if (push_req) begin
                    op = OP_PUSH;
                end else if (pop_req) begin
                    op = OP_POP;
                end
                if (op == OP_PC_LO && !bad) state_d = ST_PC_HI; // PC_START
            end
            ST_PC_HI: begin
                op      = OP_PC_HI;
                state_d = ST_IDLE;                          // PC_DONE
            end
            ST_LIM_HOLD: begin
                state_d = ST_IDLE;                          // LIM_FREE
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign access = (op != OP_NONE);
    assign bad    = access & (over | under);

    // pointer next value
    always_comb begin
        sp_d = sp_q;
        if (reg_acc && sp_wr) begin
            sp_d = reg_wdata & ALIGN_MASK;
        end else if (access && !bad) begin
            sp_d = (op == OP_POP) ? sp_dec : sp_inc;
        end
    end

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sp_q    <= SP_RST;
            hi_q    <= '0;
            trap_q  <= 1'b0;
            under_q <= 1'b0;
        end else begin
            state_q <= state_d;
            sp_q    <= sp_d;
            trap_q  <= bad;
            under_q <= bad & under;
            if (op == OP_PC_LO) hi_q <= hi_word;
        end
    end

    // limit register: no reset value
    always_ff @(posedge clk) begin
        if (reg_acc && lim_wr) lim_q <= reg_wdata & ALIGN_MASK;
    end

    // output process
    always_comb begin
        mem_addr  = acc_addr;
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        mem_wdata = '0;
        busy      = (state_q != ST_IDLE);
        unique case (op)
            OP_PUSH:  begin mem_we = ~bad; mem_wdata = push_data; end
            OP_PC_LO: begin mem_we = ~bad; mem_wdata = lo_word;   end
            OP_PC_HI: begin mem_we = ~bad; mem_wdata = hi_q;      end
            OP_POP:   begin mem_re = ~bad;                        end
            default:  mem_addr = sp_q;
        endcase
    end

    assign sp_val     = sp_q;
    assign trap       = trap_q;
    assign trap_under = under_q;

    // assertions
    AST_RESET_SP: assert property (@(posedge clk) $rose(rst_n) |-> sp_q == SP_RST); // R1
    AST_SP_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n) !sp_q[0]); // R4
    AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> sp_q == $past(sp_q) + DW'(2)); // R2
    AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> sp_q == $past(sp_q) - DW'(2)); // R3
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_re) |-> mem_addr <= lim_q); // R5
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_re) |-> mem_addr >= FLOOR); // R6
    AST_TRAP_HOLDS_SP: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> sp_q == $past(sp_q)); // R7
    AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re)); // R11
    AST_LIM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && lim_wr) |=> busy && !mem_we && !mem_re); // R10
    AST_PC_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !sp_wr && !lim_wr && pcpush_req && mem_we) |=> busy); // R8
endmodule

// File: tb/stk_ptr_unit_tb_top.sv
module stk_ptr_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_req = 0, pop_req = 0, pcpush_req = 0, pcpush_exc = 0;
    logic        sp_wr = 0, lim_wr = 0;
    logic [15:0] push_data = '0, reg_wdata = '0;
    logic [22:0] pc_val = '0;
    logic [7:0]  stat_low = '0;
    logic [15:0] mem_addr, mem_wdata, sp_val;
    logic        mem_we, mem_re, busy, trap, trap_under;

    int checks = 0;
    int errors = 0;

    logic [15:0] o_addr, o_wd, p_sp;
    logic        o_we, o_re, o_busy, p_trap, p_under, p_busy;

    stk_ptr_unit dut_i (
        .clk(clk), .rst_n(rst_n), .push_req(push_req), .pop_req(pop_req),
        .push_data(push_data), .pcpush_req(pcpush_req), .pcpush_exc(pcpush_exc),
        .pc_val(pc_val), .stat_low(stat_low), .sp_wr(sp_wr), .lim_wr(lim_wr),
        .reg_wdata(reg_wdata), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_re(mem_re), .mem_wdata(mem_wdata), .busy(busy), .sp_val(sp_val),
        .trap(trap), .trap_under(trap_under)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // one request cycle: drive at negedge, sample before and after the edge
    task automatic step(input logic pu, input logic po, input logic pc, input logic ex,
                        input logic ws, input logic wl, input logic [15:0] d);
        @(negedge clk);
        push_req = pu; pop_req = po; pcpush_req = pc; pcpush_exc = ex;
        sp_wr = ws; lim_wr = wl; push_data = d; reg_wdata = d;
        #4;
        o_addr = mem_addr; o_wd = mem_wdata; o_we = mem_we; o_re = mem_re; o_busy = busy;
        @(posedge clk);
        #2;
        p_sp = sp_val; p_trap = trap; p_under = trap_under; p_busy = busy;
        push_req = 0; pop_req = 0; pcpush_req = 0; sp_wr = 0; lim_wr = 0;
    endtask

    task automatic set_lim(input logic [15:0] v);
        step(0, 0, 0, 0, 0, 1, v);
        step(0, 0, 0, 0, 0, 0, 16'h0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [15:0] exp_sp;
        int cnt;
        repeat (3) @(posedge clk);
        #2;
        // R1 reset state
        chk(sp_val == 16'h0800, "R1 sp", sp_val, 16'h0800);
        chk(!busy && !trap && !mem_we && !mem_re, "R1 flags", {busy, trap, mem_we, mem_re}, 0);
        rst_n = 1'b1;

        // R4 limit alignment, R10 hold after limit write
        step(0, 0, 0, 0, 0, 1, 16'h0811);
        chk(p_busy, "R10 busy", p_busy, 1);
        step(1, 0, 0, 0, 0, 0, 16'h1111);
        chk(!o_we && o_busy, "R10 ignored push", {o_we, o_busy}, 2'b01);
        chk(p_sp == 16'h0800, "R10 sp", p_sp, 16'h0800);

        // R2 / R5: push sweep up to limit 0x0810
        exp_sp = 16'h0800;
        for (int k = 0; k < 10; k++) begin
            step(1, 0, 0, 0, 0, 0, 16'hA000 + 16'(k));
            if (exp_sp <= 16'h0810) begin
                chk(o_we && o_addr == exp_sp && o_wd == 16'hA000 + 16'(k), "R2 push",
                    {o_we, o_addr}, {1'b1, exp_sp});
                exp_sp = exp_sp + 2;
                chk(p_sp == exp_sp && !p_trap, "R2 step", p_sp, exp_sp);
            end else begin
                chk(!o_we, "R5 blocked", o_we, 0);
                chk(p_trap && !p_under && p_sp == exp_sp, "R5 trap", {p_trap, p_under, p_sp}, {2'b10, exp_sp});
            end
        end
        step(0, 0, 0, 0, 0, 0, 0);
        chk(!p_trap, "R7 pulse", p_trap, 0);

        // R3 / R6: pop sweep down past the floor
        for (int k = 0; k < 10; k++) begin
            step(0, 1, 0, 0, 0, 0, 0);
            if (exp_sp > 16'h0800) begin
                chk(o_re && o_addr == exp_sp - 2, "R3 pop", {o_re, o_addr}, {1'b1, 16'(exp_sp - 2)});
                exp_sp = exp_sp - 2;
                chk(p_sp == exp_sp, "R3 step", p_sp, exp_sp);
            end else begin
                chk(!o_re && p_trap && p_under && p_sp == 16'h0800, "R6 under",
                    {o_re, p_trap, p_under, p_sp}, {3'b011, 16'h0800});
            end
        end

        // R4 pointer write alignment, R7 overflow from loaded pointer
        step(0, 0, 0, 0, 1, 0, 16'h0901);
        chk(p_sp == 16'h0900, "R4 sp align", p_sp, 16'h0900);
        step(1, 0, 0, 0, 0, 0, 16'h5555);
        chk(!o_we && p_trap && !p_under && p_sp == 16'h0900, "R7 no move", {o_we, p_trap, p_sp}, {2'b01, 16'h0900});

        // R5 sweep of limits: off+1 pushes succeed
        for (int off = 0; off < 7; off++) begin
            set_lim(16'h0800 + 16'(2 * off) + 16'(off % 2));
            step(0, 0, 0, 0, 1, 0, 16'h0800);
            cnt = 0;
            for (int k = 0; k < off + 3; k++) begin
                step(1, 0, 0, 0, 0, 0, 16'(k));
                if (o_we) cnt++;
            end
            chk(cnt == off + 1, "R5 limit sweep", cnt, off + 1);
        end

        // R8 call frame
        set_lim(16'h0FFE);
        step(0, 0, 0, 0, 1, 0, 16'h0A00);
        pc_val = 23'h7F_ABCD; stat_low = 8'hC3;
        step(0, 0, 1, 0, 0, 0, 0);
        chk(o_we && o_addr == 16'h0A00 && o_wd == 16'hABCD && !o_busy, "R8 word0", {o_addr, o_wd}, {16'h0A00, 16'hABCD});
        chk(p_busy, "R8 busy", p_busy, 1);
        step(0, 1, 0, 0, 1, 0, 16'h0C00);
        chk(o_we && !o_re && o_busy && o_addr == 16'h0A02 && o_wd == 16'h007F, "R8 word1",
            {o_addr, o_wd}, {16'h0A02, 16'h007F});
        chk(p_sp == 16'h0A04 && !p_busy, "R11 busy ignores", p_sp, 16'h0A04);

        // R9 exception frame
        pc_val = 23'h12_3456; stat_low = 8'hC3;
        step(0, 0, 1, 1, 0, 0, 0);
        chk(o_wd == 16'h3456, "R9 word0", o_wd, 16'h3456);
        pc_val = 23'h0; stat_low = 8'h0;
        step(0, 0, 0, 0, 0, 0, 0);
        chk(o_we && o_addr == 16'h0A06 && o_wd == 16'hC312, "R9 word1", {o_addr, o_wd}, {16'h0A06, 16'hC312});

        // R11 priority
        step(1, 1, 0, 0, 0, 0, 16'h7777);
        chk(o_we && !o_re && o_wd == 16'h7777 && p_sp == 16'h0A0A, "R11 push over pop", p_sp, 16'h0A0A);
        step(1, 0, 0, 0, 1, 0, 16'h0B00);
        chk(!o_we && p_sp == 16'h0B00, "R11 write over push", p_sp, 16'h0B00);

        // R12 second word traps
        set_lim(16'h0B00);
        pc_val = 23'h01_2222;
        step(0, 0, 1, 0, 0, 0, 0);
        chk(o_we && o_addr == 16'h0B00, "R12 word0", o_addr, 16'h0B00);
        step(0, 0, 0, 0, 0, 0, 0);
        chk(!o_we && p_trap && !p_under && p_sp == 16'h0B02, "R12 word1 trap",
            {o_we, p_trap, p_sp}, {2'b01, 16'h0B02});

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule